// File: doc/BRIEF.md
# SCSI Bus Control Register Interface

This block sits between a host processor and a narrow (8-bit) parallel SCSI bus. The host sees eight byte-wide registers behind a 3-bit address. Through them it sets the data byte to drive and the control lines to assert, and it selects the role (initiator or target) and the checks that are armed. The block turns those settings into per-line output enables for open-collector style drivers. Every bus signal is active-high inside the block. A set enable pulls the line to its active level, and the bus data byte comes with an odd parity bit.

All incoming bus lines pass through a configurable synchronizer before they are compared or latched. The block reports the live bus lines and whether the programmed phase matches the bus. It latches one data byte on each handshake edge. It also latches parity errors, unexpected BSY loss and selection events into one sticky interrupt, which a read of address 7 clears. Arbitration timing, DMA engines and any host-side buffering are outside this block. Only the data-bus drive during arbitration and the arbitration progress and lost flags are kept.

Top module: `scsi_bus_regif`

## Requirements
- R1: After reset, every output enable and `irq` are low, the command, mode and target registers read back 0, and with all bus lines idle a read of address 5 returns 8'h08 (only the phase-match bit set).
- R2: A write to address 2 (mode) reads back all 8 bits. A write to address 1 reads back bits 7 and 4..0, with bit 6 giving arbitration-in-progress and bit 5 giving arbitration-lost. A write to address 3 reads back bits 3..0, and bits 7..4 read 0.
- R3: After the synchronizer delay, a read of address 0 returns the bus data byte and a read of address 4 returns {RST, BSY, REQ, MSG, C/D, I/O, SEL, parity} from bit 7 down.
- R4: Address-1 bits 7, 3 and 2 enable RST, BSY and SEL. Bits 4 (ACK) and 1 (ATN) drive only while mode bit 6 (target role) is clear. Address-3 bits 3..0 enable REQ, MSG, C/D and I/O only while mode bit 6 is set.
- R5: Writing address-1 bit 6 (tri-state) forces every output enable, including the data enable, low.
- R6: Address-5 bit 3 is set exactly when the synchronized {MSG, C/D, I/O} equals address-3 bits 2..0. The phases are data out 000, data in 001, command 010, status 011, message out 110 and message in 111.
- R7: The data lines are enabled while mode bit 0 (arbitrate) is set, or while address-1 bit 0 is set and the phase matches. The driven parity bit makes the nine bits odd.
- R8: In the initiator role a falling REQ, and in the target role a falling ACK, latches the bus byte into address 6.
- R9: At a latch event with mode bit 5 set, bad parity sets address-5 bit 5. `irq` rises as well only if mode bit 4 is also set. With bit 5 clear, nothing is flagged.
- R10: With mode bit 2 set, a fall of BSY sets address-5 bit 2 and raises `irq`.
- R11: When BSY is false, SEL is true and the bus data has a bit set that is also set in the select-enable register (written at address 4), `irq` rises. With no common bit, it stays low.
- R12: `irq` and the parity and busy error flags stay set until a read of address 7 clears them. Address-5 bit 4 mirrors `irq`.
- R13: While mode bit 0 is set, address-1 read bit 6 sets once BSY is seen false. Bit 5 then sets if SEL is seen on the bus while the block itself does not assert SEL. Both bits clear when mode bit 0 is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostAddr | input | 3 | Register address |
| hostWr | input | 1 | Write strobe, one cycle per access |
| hostRd | input | 1 | Read strobe; clears interrupt state at address 7 |
| hostWdata | input | 8 | Write data |
| hostRdata | output | 8 | Read data, valid in the strobe cycle |
| irq | output | 1 | Sticky interrupt request |
| busDataIn | input | 8 | Bus data lines as seen on the bus |
| busParIn | input | 1 | Bus data parity line |
| busRstIn | input | 1 | Bus RST line |
| busBsyIn | input | 1 | Bus BSY line |
| busSelIn | input | 1 | Bus SEL line |
| busAtnIn | input | 1 | Bus ATN line |
| busAckIn | input | 1 | Bus ACK line |
| busReqIn | input | 1 | Bus REQ line |
| busMsgIn | input | 1 | Bus MSG line |
| busCdIn | input | 1 | Bus C/D line |
| busIoIn | input | 1 | Bus I/O line |
| busDataOut | output | 8 | Data byte to drive |
| busParOut | output | 1 | Odd parity for busDataOut |
| busDataOe | output | 1 | Enable for data and parity drivers |
| rstOe | output | 1 | RST driver enable |
| bsyOe | output | 1 | BSY driver enable |
| selOe | output | 1 | SEL driver enable |
| atnOe | output | 1 | ATN driver enable |
| ackOe | output | 1 | ACK driver enable |
| reqOe | output | 1 | REQ driver enable |
| msgOe | output | 1 | MSG driver enable |
| cdOe | output | 1 | C/D driver enable |
| ioOe | output | 1 | I/O driver enable |

## Verification
The bound checker watches, on every cycle, the behaviour visible at the ports: the driven parity stays odd, initiator and target enables are never on together, the mode register reads back what was written, `irq` stays set until the clearing read, and the status bit mirrors `irq`. The directed scenarios have to show everything that depends on bus history through the synchronizer. This covers the phase compare and the data-drive gating, the handshake-edge latch with its parity outcomes, busy loss, the selection mask match and miss, and the arbitration progress and lost flags.

// File: rtl/scsi_regif_pkg.sv
package scsi_regif_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  // packed order of the synchronized bus vector
  localparam int B_IO  = REG_W;
  localparam int B_CD  = REG_W + 1;
  localparam int B_MSG = REG_W + 2;
  localparam int B_REQ = REG_W + 3;
  localparam int B_ACK = REG_W + 4;
  localparam int B_ATN = REG_W + 5;
  localparam int B_SEL = REG_W + 6;
  localparam int B_BSY = REG_W + 7;
  localparam int B_RST = REG_W + 8;
  localparam int B_PAR = REG_W + 9;
  localparam int BUS_W = REG_W + 10;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA = 3'd0, A_ICR = 3'd1, A_MODE = 3'd2, A_TCR = 3'd3,
    A_STAT = 3'd4, A_BASR = 3'd5, A_IN = 3'd6, A_CLR = 3'd7
  } regAddr_e;

  typedef struct packed {
    logic wrOut;
    logic wrIcr;
    logic wrMode;
    logic wrTcr;
    logic wrSelEn;
    logic rdClr;
  } regStrobe_t;

  typedef struct packed {
    logic [REG_W-1:0] curData;
    logic [REG_W-1:0] icrRd;
    logic [REG_W-1:0] mode;
    logic [REG_W-1:0] tcrRd;
    logic [REG_W-1:0] busStat;
    logic [REG_W-1:0] basr;
    logic [REG_W-1:0] inData;
  } regView_t;
endpackage

// File: rtl/scsi_regif_sync.sv
module scsi_regif_sync #(
  parameter int WIDTH  = 18,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else if (s == 0) stage[s] <= asyncIn;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/scsi_regif_ctrl.sv
module scsi_regif_ctrl
  import scsi_regif_pkg::*;
(
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  regView_t          view,
  output regStrobe_t        strb,
  output logic [REG_W-1:0]  rdData
);
  regAddr_e addrE;
  assign addrE = regAddr_e'(hostAddr);

  always_comb begin
    strb         = '0;
    strb.wrOut   = hostWr && addrE == A_DATA;
    strb.wrIcr   = hostWr && addrE == A_ICR;
    strb.wrMode  = hostWr && addrE == A_MODE;
    strb.wrTcr   = hostWr && addrE == A_TCR;
    strb.wrSelEn = hostWr && addrE == A_STAT;
    strb.rdClr   = hostRd && addrE == A_CLR;
  end

  always_comb begin
    case (addrE)
      A_DATA:  rdData = view.curData;
      A_ICR:   rdData = view.icrRd;
      A_MODE:  rdData = view.mode;
      A_TCR:   rdData = view.tcrRd;
      A_STAT:  rdData = view.busStat;
      A_BASR:  rdData = view.basr;
      A_IN:    rdData = view.inData;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/scsi_regif_dp.sv
module scsi_regif_dp
  import scsi_regif_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strb,
  input  logic [REG_W-1:0] hostWdata,
  input  logic [BUS_W-1:0] sBus,
  output regView_t         view,
  output logic             irq,
  output logic [REG_W-1:0] busDataOut,
  output logic             busParOut,
  output logic             busDataOe,
  output logic             rstOe,
  output logic             bsyOe,
  output logic             selOe,
  output logic             atnOe,
  output logic             ackOe,
  output logic             reqOe,
  output logic             msgOe,
  output logic             cdOe,
  output logic             ioOe
);
  logic [REG_W-1:0] outReg, modeReg, selEnReg, inReg;
  logic [3:0]       tcrReg;
  logic icrRst, icrTri, icrAck, icrBsy, icrSel, icrAtn, icrData;
  logic arbBusy, arbLost, parErr, busyErr;
  logic prevReq, prevAck, prevBsy, selCondQ;

  logic [REG_W-1:0] sData;
  logic sIo, sCd, sMsg, sReq, sAck, sAtn, sSel, sBsy, sRst, sPar;
  assign sData = sBus[REG_W-1:0];
  assign sIo   = sBus[B_IO];
  assign sCd   = sBus[B_CD];
  assign sMsg  = sBus[B_MSG];
  assign sReq  = sBus[B_REQ];
  assign sAck  = sBus[B_ACK];
  assign sAtn  = sBus[B_ATN];
  assign sSel  = sBus[B_SEL];
  assign sBsy  = sBus[B_BSY];
  assign sRst  = sBus[B_RST];
  assign sPar  = sBus[B_PAR];

  logic tgtMode, parCheck, parIntr, monBsy, arbitrate;
  assign tgtMode   = modeReg[6];
  assign parCheck  = modeReg[5];
  assign parIntr   = modeReg[4];
  assign monBsy    = modeReg[2];
  assign arbitrate = modeReg[0];

  // phase compare and drive gating
  logic phaseMatch, drvOk;
  assign phaseMatch = {sMsg, sCd, sIo} == tcrReg[2:0];
  assign drvOk      = !icrTri;

  assign busDataOut = outReg;
  assign busParOut  = ~^outReg;
  assign busDataOe  = drvOk && (arbitrate || (icrData && phaseMatch));
  assign rstOe      = drvOk && icrRst;
  assign bsyOe      = drvOk && icrBsy;
  assign selOe      = drvOk && icrSel;
  assign atnOe      = drvOk && icrAtn && !tgtMode;
  assign ackOe      = drvOk && icrAck && !tgtMode;
  assign reqOe      = drvOk && tgtMode && tcrReg[3];
  assign msgOe      = drvOk && tgtMode && tcrReg[2];
  assign cdOe       = drvOk && tgtMode && tcrReg[1];
  assign ioOe       = drvOk && tgtMode && tcrReg[0];

  // event detection on synchronized lines
  logic latchEvt, badPar, parSet, bsyFall, selCond, selRise, irqSet;
  assign latchEvt = tgtMode ? (prevAck && !sAck) : (prevReq && !sReq);
  assign badPar   = ~^{sData, sPar};
  assign parSet   = latchEvt && parCheck && badPar;
  assign bsyFall  = monBsy && prevBsy && !sBsy;
  assign selCond  = !sBsy && sSel && |(sData & selEnReg);
  assign selRise  = selCond && !selCondQ;
  assign irqSet   = selRise || (parSet && parIntr) || bsyFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg   <= '0;
      modeReg  <= '0;
      selEnReg <= '0;
      tcrReg   <= '0;
      {icrRst, icrTri, icrAck, icrBsy, icrSel, icrAtn, icrData} <= '0;
    end else begin
      if (strb.wrOut)   outReg   <= hostWdata;
      if (strb.wrMode)  modeReg  <= hostWdata;
      if (strb.wrSelEn) selEnReg <= hostWdata;
      if (strb.wrTcr)   tcrReg   <= hostWdata[3:0];
      if (strb.wrIcr) begin
        icrRst  <= hostWdata[7];
        icrTri  <= hostWdata[6];
        icrAck  <= hostWdata[4];
        icrBsy  <= hostWdata[3];
        icrSel  <= hostWdata[2];
        icrAtn  <= hostWdata[1];
        icrData <= hostWdata[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevReq  <= 1'b0;
      prevAck  <= 1'b0;
      prevBsy  <= 1'b0;
      selCondQ <= 1'b0;
      inReg    <= '0;
      arbBusy  <= 1'b0;
      arbLost  <= 1'b0;
    end else begin
      prevReq  <= sReq;
      prevAck  <= sAck;
      prevBsy  <= sBsy;
      selCondQ <= selCond;
      if (latchEvt) inReg <= sData;
      if (!arbitrate) begin
        arbBusy <= 1'b0;
        arbLost <= 1'b0;
      end else begin
        arbBusy <= arbBusy || !sBsy;
        arbLost <= arbLost || (arbBusy && sSel && !icrSel);
      end
    end
  end

  // sticky flags: a new event in the clearing cycle wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq     <= 1'b0;
      parErr  <= 1'b0;
      busyErr <= 1'b0;
    end else begin
      irq     <= irqSet  || (irq     && !strb.rdClr);
      parErr  <= parSet  || (parErr  && !strb.rdClr);
      busyErr <= bsyFall || (busyErr && !strb.rdClr);
    end
  end

  always_comb begin
    view.curData = sData;
    view.icrRd   = {icrRst, arbBusy, arbLost, icrAck, icrBsy, icrSel, icrAtn, icrData};
    view.mode    = modeReg;
    view.tcrRd   = {4'b0000, tcrReg};
    view.busStat = {sRst, sBsy, sReq, sMsg, sCd, sIo, sSel, sPar};
    view.basr    = {2'b00, parErr, irq, phaseMatch, busyErr, sAtn, sAck};
    view.inData  = inReg;
  end
endmodule

// File: rtl/scsi_bus_regif.sv
module scsi_bus_regif
  import scsi_regif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [REG_W-1:0]  hostWdata,
  output logic [REG_W-1:0]  hostRdata,
  output logic              irq,
  input  logic [REG_W-1:0]  busDataIn,
  input  logic              busParIn,
  input  logic              busRstIn,
  input  logic              busBsyIn,
  input  logic              busSelIn,
  input  logic              busAtnIn,
  input  logic              busAckIn,
  input  logic              busReqIn,
  input  logic              busMsgIn,
  input  logic              busCdIn,
  input  logic              busIoIn,
  output logic [REG_W-1:0]  busDataOut,
  output logic              busParOut,
  output logic              busDataOe,
  output logic              rstOe,
  output logic              bsyOe,
  output logic              selOe,
  output logic              atnOe,
  output logic              ackOe,
  output logic              reqOe,
  output logic              msgOe,
  output logic              cdOe,
  output logic              ioOe
);
  logic [BUS_W-1:0] rawBus, sBus;
  regStrobe_t       strb;
  regView_t         view;

  assign rawBus = {busParIn, busRstIn, busBsyIn, busSelIn, busAtnIn,
                   busAckIn, busReqIn, busMsgIn, busCdIn, busIoIn, busDataIn};

  scsi_regif_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(rawBus), .syncOut(sBus)
  );

  scsi_regif_ctrl u_ctrl (
    .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .view(view), .strb(strb), .rdData(hostRdata)
  );

  scsi_regif_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostWdata(hostWdata), .sBus(sBus),
    .view(view), .irq(irq), .busDataOut(busDataOut), .busParOut(busParOut),
    .busDataOe(busDataOe), .rstOe(rstOe), .bsyOe(bsyOe), .selOe(selOe),
    .atnOe(atnOe), .ackOe(ackOe), .reqOe(reqOe), .msgOe(msgOe),
    .cdOe(cdOe), .ioOe(ioOe)
  );
endmodule

// File: rtl/scsi_regif_chk.sv
module scsi_regif_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] hostAddr,
  input logic       hostWr,
  input logic       hostRd,
  input logic [7:0] hostWdata,
  input logic [7:0] hostRdata,
  input logic       irq,
  input logic [7:0] busDataOut,
  input logic       busParOut,
  input logic       busDataOe,
  input logic       ackOe,
  input logic       atnOe,
  input logic       reqOe,
  input logic       msgOe,
  input logic       cdOe,
  input logic       ioOe
);
  // R7: driven parity keeps the nine data bits odd
  a_r7_odd_parity: assert property (@(posedge clk) disable iff (!rstN)
    busDataOe |-> (^{busDataOut, busParOut}) == 1'b1);

  // R4: initiator-only and target-only enables never coexist
  a_r4_role_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    (reqOe || msgOe || cdOe || ioOe) |-> !(ackOe || atnOe));

  // R2: a mode write is returned by an immediately following read
  a_r2_mode_readback: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == 3'd2) ##1 (hostRd && hostAddr == 3'd2)
      |-> hostRdata == $past(hostWdata));

  // R12: interrupt is sticky until the clearing read
  a_r12_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(hostRd && hostAddr == 3'd7)) |=> irq);

  // R12: status bit 4 mirrors the interrupt
  a_r12_irq_mirror: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr == 3'd5) |-> hostRdata[4] == irq);
endmodule

bind scsi_bus_regif scsi_regif_chk u_chk (.*);

// File: tb/scsi_bus_regif_test.sv
module scsi_bus_regif_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] hostAddr = '0;
  logic       hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0] hostWdata = '0, hostRdata;
  logic       irq;
  logic [7:0] busDataIn = '0;
  logic busParIn = 0, busRstIn = 0, busBsyIn = 0, busSelIn = 0, busAtnIn = 0;
  logic busAckIn = 0, busReqIn = 0, busMsgIn = 0, busCdIn = 0, busIoIn = 0;
  logic [7:0] busDataOut;
  logic busParOut, busDataOe, rstOe, bsyOe, selOe, atnOe, ackOe, reqOe, msgOe, cdOe, ioOe;

  int nTests = 0, nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  scsi_bus_regif uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    hostAddr = a; hostRd = 1'b1;
    #1 d = hostRdata;
    @(posedge clk);
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic idle();
    logic [7:0] d;
    wr(3'd2, 8'h00); wr(3'd1, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    busDataIn = '0; {busParIn, busRstIn, busBsyIn, busSelIn, busAtnIn} = '0;
    {busAckIn, busReqIn, busMsgIn, busCdIn, busIoIn} = '0;
    settle();
    rd(3'd7, d);
    settle();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check(irq == 0, "R1 irq", irq, 0);
    check({busDataOe, rstOe, bsyOe, selOe, atnOe, ackOe, reqOe, msgOe, cdOe, ioOe} == 0,
          "R1 enables", {busDataOe, rstOe, bsyOe, selOe, atnOe, ackOe, reqOe, msgOe, cdOe, ioOe}, 0);
    @(negedge clk);
    rd(3'd1, d); check(d == 8'h00, "R1 icr", d, 8'h00);
    rd(3'd2, d); check(d == 8'h00, "R1 mode", d, 8'h00);
    rd(3'd5, d); check(d == 8'h08, "R1 basr", d, 8'h08);
  endtask

  task automatic t_readback();
    logic [7:0] d;
    wr(3'd2, 8'hA9); rd(3'd2, d); check(d == 8'hA9, "R2 mode", d, 8'hA9);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'hFA); rd(3'd3, d); check(d == 8'h0A, "R2 tcr", d, 8'h0A);
    wr(3'd1, 8'h35); rd(3'd1, d); check(d == 8'h15, "R2 icr", d, 8'h15);
    idle();
  endtask

  task automatic t_status();
    logic [7:0] d;
    busDataIn = 8'hA5; busRstIn = 1; busBsyIn = 1; busMsgIn = 1; busIoIn = 1; busParIn = 1;
    settle();
    rd(3'd0, d); check(d == 8'hA5, "R3 data", d, 8'hA5);
    rd(3'd4, d); check(d == 8'hD5, "R3 status", d, 8'hD5);
    idle();
  endtask

  task automatic t_enables();
    wr(3'd1, 8'h9E);
    check({rstOe, ackOe, bsyOe, selOe, atnOe} == 5'b11111, "R4 initiator",
          {rstOe, ackOe, bsyOe, selOe, atnOe}, 5'b11111);
    check({reqOe, msgOe, cdOe, ioOe} == 0, "R4 no target lines", {reqOe, msgOe, cdOe, ioOe}, 0);
    wr(3'd2, 8'h40); wr(3'd3, 8'h0F);
    check({reqOe, msgOe, cdOe, ioOe} == 4'hF, "R4 target", {reqOe, msgOe, cdOe, ioOe}, 4'hF);
    check(ackOe == 0 && atnOe == 0, "R4 ack gated", {ackOe, atnOe}, 0);
    wr(3'd2, 8'h41);
    check(busDataOe == 1, "R7 arbitrate drive", busDataOe, 1);
    wr(3'd1, 8'hDE);
    check({busDataOe, rstOe, bsyOe, selOe, atnOe, ackOe, reqOe, msgOe, cdOe, ioOe} == 0,
          "R5 tristate", {busDataOe, rstOe, bsyOe, selOe, atnOe, ackOe, reqOe, msgOe, cdOe, ioOe}, 0);
    idle();
  endtask

  task automatic t_phase();
    logic [7:0] d;
    wr(3'd0, 8'h6C); wr(3'd3, 8'h03); wr(3'd1, 8'h01);
    busCdIn = 1; busIoIn = 1; settle();
    rd(3'd5, d); check(d[3] == 1, "R6 status phase match", d, 8'h08);
    check(busDataOe == 1, "R7 phase drive", busDataOe, 1);
    check(busDataOut == 8'h6C && busParOut == 1'b1, "R7 parity", {busDataOut, busParOut}, {8'h6C, 1'b1});
    busMsgIn = 1; busCdIn = 1; busIoIn = 0; settle();
    rd(3'd5, d); check(d[3] == 0, "R6 message out mismatch", d[3], 0);
    check(busDataOe == 0, "R7 no drive on mismatch", busDataOe, 0);
    wr(3'd3, 8'h06); settle();
    rd(3'd5, d); check(d[3] == 1, "R6 message out match", d[3], 1);
    idle();
  endtask

  task automatic strobe(input logic [7:0] dat, input logic par);
    busDataIn = dat; busParIn = par; busReqIn = 1; settle();
    busReqIn = 0; settle();
  endtask

  task automatic t_parity();
    logic [7:0] d;
    wr(3'd2, 8'h30);
    strobe(8'h03, 1'b1);
    rd(3'd6, d); check(d == 8'h03, "R8 latch", d, 8'h03);
    rd(3'd5, d); check(d[5] == 0 && irq == 0, "R9 good parity", {d[5], irq}, 0);
    strobe(8'h5A, 1'b0);
    rd(3'd6, d); check(d == 8'h5A, "R8 latch second", d, 8'h5A);
    rd(3'd5, d); check(d[5] == 1 && irq == 1, "R9 bad parity irq", {d[5], irq}, 2'b11);
    rd(3'd7, d); settle();
    rd(3'd5, d); check(d[5] == 0 && irq == 0, "R12 clear", {d[5], irq}, 0);
    wr(3'd2, 8'h20);
    strobe(8'h03, 1'b0);
    rd(3'd5, d); check(d[5] == 1 && irq == 0, "R9 flag without irq", {d[5], irq}, 2'b10);
    rd(3'd7, d);
    wr(3'd2, 8'h00);
    strobe(8'h03, 1'b0);
    rd(3'd5, d); check(d[5] == 0, "R9 check disabled", d[5], 0);
    idle();
  endtask

  task automatic t_busy();
    logic [7:0] d;
    wr(3'd2, 8'h04);
    busBsyIn = 1; settle();
    check(irq == 0, "R10 no irq while busy", irq, 0);
    busBsyIn = 0; settle();
    rd(3'd5, d); check(d[2] == 1 && d[4] == 1, "R10 busy loss", d, 8'h14);
    settle();
    check(irq == 1, "R12 irq held", irq, 1);
    rd(3'd7, d); settle();
    rd(3'd5, d); check(d[2] == 0 && irq == 0, "R12 clear busy", {d[2], irq}, 0);
    idle();
  endtask

  task automatic t_select();
    wr(3'd4, 8'h04);
    busSelIn = 1; busDataIn = 8'h08; settle();
    check(irq == 0, "R11 mask miss", irq, 0);
    busDataIn = 8'h04; settle();
    check(irq == 1, "R11 selection", irq, 1);
    idle();
  endtask

  task automatic t_arb();
    logic [7:0] d;
    busBsyIn = 1; wr(3'd2, 8'h01); settle();
    rd(3'd1, d); check(d[6] == 0, "R13 wait bus free", d[6], 0);
    busBsyIn = 0; settle();
    rd(3'd1, d); check(d[6:5] == 2'b10, "R13 in progress", d[6:5], 2'b10);
    busSelIn = 1; settle();
    rd(3'd1, d); check(d[6:5] == 2'b11, "R13 lost", d[6:5], 2'b11);
    wr(3'd2, 8'h00); @(negedge clk);
    rd(3'd1, d); check(d[6:5] == 2'b00, "R13 cleared", d[6:5], 0);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_readback();
    t_status();
    t_enables();
    t_phase();
    t_parity();
    t_busy();
    t_select();
    t_arb();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nTests++; nFail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule